// File: doc/BRIEF.md
# ADC Power Level Inserter

This block measures the mean power of a stream of signed ADC samples and delivers the result over a 64-bit payload link that already exists, so the result needs no separate read path. It takes one sample per clock and squares it. The squares are summed over a window of 2^N samples, with N chosen by a configuration input. When a window closes, the sum is divided by the window length and the result is clamped to 16 bits.

The 16-bit level is held in a one-entry pending slot. It goes out on the link in the first cycle in which the payload source is not presenting valid data. In that cycle the link valid is high and a side flag is raised, so a receiver can separate the level word from ordinary traffic. Payload data is never delayed or displaced. If a newer level is ready before the pending one has gone out, the newer level replaces it and a sticky overrun indication is raised.

Top module: `adc_level_inserter`

## Requirements
- R1: A synchronous reset clears the accumulator, the sample count, the pending slot and the overrun flag. While reset is held, `link_vld`, `link_oob` and `lvl_overrun` are all low.
- R2: In every cycle with `pay_vld` high, `link_vld` is 1, `link_oob` is 0 and `link_data` equals `pay_data` in the same cycle.
- R3: The level is floor(sum of sample squares / 2^N). It is carried in `link_data[15:0]`, and `link_data[63:16]` is zero in a level cycle.
- R4: If the quotient exceeds 16 bits, the level saturates to 16'hFFFF.
- R5: A window holds exactly 2^N consecutive samples, with N = `cfg_win_log2`. The sample that follows the last sample of a window is the first sample of the next window, and no sum carries over between windows.
- R6: A level word is driven only in a cycle with `pay_vld` low. In that cycle `link_vld` and `link_oob` are both 1. While `pay_vld` stays high, the level waits.
- R7: Each pending level is emitted exactly once.
- R8: If a window completes while an earlier level is still pending and unsent, the newer level replaces the older one and `lvl_overrun` goes to 1. It stays at 1 until reset.
- R9: With the link idle, a level word appears two cycles after the cycle that presented the last sample of its window.
- R10: Samples are two's complement, so a negative sample contributes the same square as its magnitude.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| adc_sample | input | SAMPLE_W | Signed ADC sample, one per cycle |
| cfg_win_log2 | input | LOG2_W | Window exponent N (window = 2^N samples) |
| pay_vld | input | 1 | Payload word valid |
| pay_data | input | WORD_W | Payload word |
| link_vld | output | 1 | Merged stream valid |
| link_data | output | WORD_W | Merged stream word |
| link_oob | output | 1 | High when the word carries a level |
| lvl_overrun | output | 1 | Sticky: a pending level was overwritten |

## Verification
The bench targets the window boundary. Back-to-back windows with different sample values catch a design that leaks one window's sum into the next, or that closes a window one sample early or late. A burst of payload that spans a window completion checks that the level is held off until the first idle cycle and sent only once; a design with a faulty slot would either corrupt a payload word or repeat the level. Full-scale negative samples test the saturation path and signed squaring, and a window length of one sample under continuous payload forces overwrites, where a design that lost the sticky flag, or kept the older value, shows a wrong word or a low `lvl_overrun`.

// File: rtl/adc_lvl_pkg.sv
package adc_lvl_pkg;
    localparam int LEVEL_W = 16;

    typedef enum logic {
        SLOT_IDLE = 1'b0,
        SLOT_HELD = 1'b1
    } slot_state_t;
endpackage

// File: rtl/adc_sq_acc.sv
// Squares each sample and sums over a window of 2^N samples.
module adc_sq_acc #(
    parameter int SAMPLE_W = 10,
    parameter int MAX_LOG2 = 16,
    parameter int LOG2_W   = 5,
    parameter int ACC_W    = 36
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic signed [SAMPLE_W-1:0] sample,
    input  logic [LOG2_W-1:0]          cfg_log2,
    output logic                       win_done,
    output logic [ACC_W-1:0]           win_sum,
    output logic [LOG2_W-1:0]          win_log2
);
    localparam int CNT_W = (MAX_LOG2 > 0) ? MAX_LOG2 : 1;
    localparam int SQ_W  = 2 * SAMPLE_W;

    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic [ACC_W-1:0]  acc;
        logic              done;
        logic [ACC_W-1:0]  sum;
        logic [LOG2_W-1:0] n;
    } acc_st_t;

    acc_st_t st_d, st_q;

    logic signed [SQ_W-1:0] sq_s;
    logic [SQ_W-1:0]        sq_u;
    logic [LOG2_W-1:0]      n_eff;
    logic [CNT_W-1:0]       lim;
    logic [ACC_W-1:0]       acc_next;
    logic                   last;

    assign sq_s  = sample * sample;
    assign sq_u  = sq_s;
    assign n_eff = (cfg_log2 > LOG2_W'(MAX_LOG2)) ? LOG2_W'(MAX_LOG2) : cfg_log2;

    // 2^n - 1: every bit below n set
    always_comb begin
        for (int i = 0; i < CNT_W; i++) begin
            lim[i] = (LOG2_W'(i) < n_eff);
        end
    end

    always_comb begin
        st_d     = st_q;
        acc_next = st_q.acc + ACC_W'(sq_u);
        last     = (st_q.cnt >= lim);
        st_d.done = last;
        if (last) begin
            st_d.sum = acc_next;
            st_d.n   = n_eff;
            st_d.acc = '0;
            st_d.cnt = '0;
        end else begin
            st_d.acc = acc_next;
            st_d.cnt = st_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign win_done = st_q.done;
    assign win_sum  = st_q.sum;
    assign win_log2 = st_q.n;

    // R5: a completed window of more than one sample is not followed at once by another
    p_window_restart_r5: assert property (@(posedge clk) disable iff (rst)
        (st_q.done && lim != '0) ##1 $stable(cfg_log2) |-> !st_q.done);
endmodule

// File: rtl/adc_lvl_quant.sv
// Divides the window sum by 2^N and clamps it to the level width.
module adc_lvl_quant #(
    parameter int ACC_W   = 36,
    parameter int LOG2_W  = 5,
    parameter int LEVEL_W = 16
) (
    input  logic [ACC_W-1:0]   sum,
    input  logic [LOG2_W-1:0]  shamt,
    output logic [LEVEL_W-1:0] level
);
    logic [ACC_W-1:0] shifted;
    assign shifted = sum >> shamt;

    generate
        if (ACC_W > LEVEL_W) begin : g_sat
            logic over;
            assign over  = |shifted[ACC_W-1:LEVEL_W];
            assign level = over ? '1 : shifted[LEVEL_W-1:0];
        end else begin : g_pass
            assign level = LEVEL_W'(shifted);
        end
    endgenerate
endmodule

// File: rtl/adc_lvl_slot.sv
// One-entry pending slot; merges the level into idle link cycles.
module adc_lvl_slot
    import adc_lvl_pkg::*;
#(
    parameter int WORD_W = 64
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               load,
    input  logic [LEVEL_W-1:0] load_level,
    input  logic               pay_vld,
    input  logic [WORD_W-1:0]  pay_data,
    output logic               out_vld,
    output logic [WORD_W-1:0]  out_data,
    output logic               out_oob,
    output logic               overrun
);
    typedef struct packed {
        slot_state_t        st;
        logic [LEVEL_W-1:0] lvl;
        logic               ovr;
    } slot_t;

    slot_t sl_d, sl_q;
    logic  sent;

    assign sent = (sl_q.st == SLOT_HELD) && !pay_vld;

    always_comb begin
        sl_d = sl_q;
        if (load) begin
            sl_d.st  = SLOT_HELD;
            sl_d.lvl = load_level;
            if ((sl_q.st == SLOT_HELD) && !sent) begin
                sl_d.ovr = 1'b1;
            end
        end else if (sent) begin
            sl_d.st = SLOT_IDLE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sl_q <= '{st: SLOT_IDLE, lvl: '0, ovr: 1'b0};
        end else begin
            sl_q <= sl_d;
        end
    end

    assign out_vld  = pay_vld || (sl_q.st == SLOT_HELD);
    assign out_oob  = sent;
    assign out_data = pay_vld ? pay_data : WORD_W'(sl_q.lvl);
    assign overrun  = sl_q.ovr;

    p_pass_r2: assert property (@(posedge clk) disable iff (rst)
        pay_vld |-> (out_vld && !out_oob));
    p_upper_zero_r3: assert property (@(posedge clk) disable iff (rst)
        out_oob |-> (out_data[WORD_W-1:LEVEL_W] == '0));
    p_idle_only_r6: assert property (@(posedge clk) disable iff (rst)
        out_oob |-> (!pay_vld && out_vld));
    p_sent_once_r7: assert property (@(posedge clk) disable iff (rst)
        (out_oob && !load) |=> (sl_q.st == SLOT_IDLE));
    p_overrun_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        overrun |=> overrun);
endmodule

// File: rtl/adc_level_inserter.sv
module adc_level_inserter
    import adc_lvl_pkg::*;
#(
    parameter int SAMPLE_W = 10,
    parameter int MAX_LOG2 = 16,
    parameter int WORD_W   = 64,
    localparam int LOG2_W  = $clog2(MAX_LOG2 + 1),
    localparam int ACC_W   = 2 * SAMPLE_W + MAX_LOG2
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic signed [SAMPLE_W-1:0] adc_sample,
    input  logic [LOG2_W-1:0]          cfg_win_log2,
    input  logic                       pay_vld,
    input  logic [WORD_W-1:0]          pay_data,
    output logic                       link_vld,
    output logic [WORD_W-1:0]          link_data,
    output logic                       link_oob,
    output logic                       lvl_overrun
);
    logic               win_done;
    logic [ACC_W-1:0]   win_sum;
    logic [LOG2_W-1:0]  win_log2;
    logic [LEVEL_W-1:0] win_level;

    adc_sq_acc #(
        .SAMPLE_W(SAMPLE_W),
        .MAX_LOG2(MAX_LOG2),
        .LOG2_W  (LOG2_W),
        .ACC_W   (ACC_W)
    ) u_acc (
        .clk     (clk),
        .rst     (rst),
        .sample  (adc_sample),
        .cfg_log2(cfg_win_log2),
        .win_done(win_done),
        .win_sum (win_sum),
        .win_log2(win_log2)
    );

    adc_lvl_quant #(
        .ACC_W  (ACC_W),
        .LOG2_W (LOG2_W),
        .LEVEL_W(LEVEL_W)
    ) u_quant (
        .sum  (win_sum),
        .shamt(win_log2),
        .level(win_level)
    );

    adc_lvl_slot #(
        .WORD_W(WORD_W)
    ) u_slot (
        .clk       (clk),
        .rst       (rst),
        .load      (win_done),
        .load_level(win_level),
        .pay_vld   (pay_vld),
        .pay_data  (pay_data),
        .out_vld   (link_vld),
        .out_data  (link_data),
        .out_oob   (link_oob),
        .overrun   (lvl_overrun)
    );
endmodule

// File: tb/adc_level_inserter_bench.sv
`timescale 1ns/1ps
module adc_level_inserter_bench;
    localparam int SAMPLE_W = 10;
    localparam int MAX_LOG2 = 16;
    localparam int WORD_W   = 64;
    localparam int LOG2_W   = $clog2(MAX_LOG2 + 1);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic signed [SAMPLE_W-1:0] adc_sample = '0;
    logic [LOG2_W-1:0] cfg_win_log2 = '0;
    logic pay_vld = 1'b0;
    logic [WORD_W-1:0] pay_data = '0;
    logic link_vld, link_oob, lvl_overrun;
    logic [WORD_W-1:0] link_data;

    always #2 clk = ~clk;

    adc_level_inserter #(
        .SAMPLE_W(SAMPLE_W), .MAX_LOG2(MAX_LOG2), .WORD_W(WORD_W)
    ) u_adc_level_inserter (
        .clk(clk), .rst(rst), .adc_sample(adc_sample), .cfg_win_log2(cfg_win_log2),
        .pay_vld(pay_vld), .pay_data(pay_data), .link_vld(link_vld),
        .link_data(link_data), .link_oob(link_oob), .lvl_overrun(lvl_overrun)
    );

    int n_checks = 0;
    int n_fail   = 0;

    // reference model state
    int          m_n;
    longint      m_cnt, m_sum;
    bit          m_rdy;
    logic [15:0] m_rdy_lvl;
    bit          m_pend;
    logic [15:0] m_plvl;
    bit          m_ovr;

    // capture of observed level words
    int          idx;
    int          first_oob;
    int          lv_n;
    logic [15:0] lv [0:15];

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [15:0] ref_level(input longint sum, input int n);
        longint q;
        q = sum / (longint'(1) << n);
        return (q > 65535) ? 16'hFFFF : q[15:0];
    endfunction

    task automatic do_reset(input int n);
        @(posedge clk); #1;
        rst = 1'b1; cfg_win_log2 = LOG2_W'(n); pay_vld = 1'b0; adc_sample = '0; pay_data = '0;
        @(posedge clk); #1;
        check(!link_vld && !link_oob && !lvl_overrun, "R1", "reset outputs",
              {link_vld, link_oob, lvl_overrun}, 0);
        m_n = n; m_cnt = 0; m_sum = 0; m_rdy = 0; m_rdy_lvl = '0;
        m_pend = 0; m_plvl = '0; m_ovr = 0;
        idx = 0; first_oob = -1; lv_n = 0;
    endtask

    task automatic step(input int s, input bit pv, input logic [WORD_W-1:0] pd, input string tag);
        bit e_vld, e_oob, sent;
        logic [WORD_W-1:0] e_data;
        @(posedge clk); #1;
        rst = 1'b0; adc_sample = SAMPLE_W'(s); pay_vld = pv; pay_data = pd;
        #1;
        e_vld  = pv | m_pend;
        e_oob  = !pv & m_pend;
        e_data = pv ? pd : {48'b0, m_plvl};
        check(link_vld == e_vld && link_oob == e_oob && lvl_overrun == m_ovr,
              tag, "flags vld/oob/ovr", {link_vld, link_oob, lvl_overrun}, {e_vld, e_oob, m_ovr});
        if (e_vld)
            check(link_data == e_data, tag, "link_data", link_data, e_data);
        if (link_oob) begin
            if (first_oob < 0) first_oob = idx;
            if (lv_n < 16) lv[lv_n] = link_data[15:0];
            lv_n++;
        end
        // model update at the coming edge
        sent = m_pend && !pv;
        if (m_rdy) begin
            if (m_pend && !sent) m_ovr = 1;
            m_pend = 1; m_plvl = m_rdy_lvl;
        end else if (sent) begin
            m_pend = 0;
        end
        m_sum += longint'(s) * longint'(s);
        m_cnt++;
        m_rdy = 0;
        if (m_cnt == (longint'(1) << m_n)) begin
            m_rdy = 1; m_rdy_lvl = ref_level(m_sum, m_n);
            m_sum = 0; m_cnt = 0;
        end
        idx++;
    endtask

    task automatic t_reset_state();
        do_reset(2);
        step(0, 0, '0, "R1");
        check(!link_vld && !link_oob && !lvl_overrun, "R1", "idle after reset",
              {link_vld, link_oob, lvl_overrun}, 0);
    endtask

    task automatic t_basic_latency();
        do_reset(2);
        for (int i = 0; i < 4; i++) step(3, 0, '0, "R3");
        for (int i = 0; i < 3; i++) step(0, 0, '0, "R9");
        check(first_oob == 5, "R9", "level cycle index", first_oob, 5);
        check(lv_n == 1, "R7", "level word count", lv_n, 1);
        check(lv[0] == 16'd9, "R3", "level value", lv[0], 9);
    endtask

    task automatic t_boundary();
        do_reset(2);
        for (int i = 0; i < 4; i++) step(1, 0, '0, "R5");
        for (int i = 0; i < 4; i++) step(2, 0, '0, "R5");
        for (int i = 0; i < 3; i++) step(0, 0, '0, "R5");
        check(lv_n == 2, "R5", "two windows", lv_n, 2);
        check(lv[0] == 16'd1, "R5", "first window", lv[0], 1);
        check(lv[1] == 16'd4, "R5", "second window clean", lv[1], 4);
    endtask

    task automatic t_busy_hold();
        do_reset(4);
        for (int i = 0; i < 16; i++) step(5, 0, '0, "R3");
        for (int i = 0; i < 6; i++) step(0, 1, {32'hA5A5_0000, 32'(i)}, "R2");
        for (int i = 0; i < 2; i++) step(0, 0, '0, "R6");
        check(first_oob == 22, "R6", "level waits for idle", first_oob, 22);
        check(lv_n == 1 && lv[0] == 16'd25, "R6", "held level", lv[0], 25);
    endtask

    task automatic t_saturate();
        do_reset(0);
        step(-512, 0, '0, "R4");
        step(255, 0, '0, "R4");
        step(0, 0, '0, "R4");
        step(0, 0, '0, "R4");
        check(lv[0] == 16'hFFFF, "R4", "saturated level", lv[0], 16'hFFFF);
        check(lv[1] == 16'hFE01, "R4", "unsaturated level", lv[1], 16'hFE01);
    endtask

    task automatic t_negative();
        do_reset(1);
        step(-7, 0, '0, "R10");
        step(7, 0, '0, "R10");
        step(7, 0, '0, "R10");
        step(7, 0, '0, "R10");
        step(0, 0, '0, "R10");
        step(0, 0, '0, "R10");
        check(lv[0] == 16'd49 && lv[1] == 16'd49, "R10", "signed square",
              {lv[0], lv[1]}, {16'd49, 16'd49});
    endtask

    task automatic t_overrun();
        do_reset(0);
        for (int i = 1; i <= 6; i++) step(i, 1, 64'(i) << 40, "R8");
        for (int i = 0; i < 4; i++) step(0, 0, '0, "R8");
        check(lv[0] == 16'd25, "R8", "newest level kept", lv[0], 25);
        check(lvl_overrun == 1'b1, "R8", "sticky overrun", lvl_overrun, 1);
        do_reset(0);
        check(lvl_overrun == 1'b0, "R1", "overrun cleared by reset", lvl_overrun, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        t_reset_state();
        t_basic_latency();
        t_boundary();
        t_busy_hold();
        t_saturate();
        t_negative();
        t_overrun();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule